// File: doc/BRIEF.md
# Soft and Auto Mute Controller

This block sits in the stereo PCM sample path of a digital audio decoder, between the input decoder and the interpolation stages. It has two mute paths that work independently. The first is a soft mute. When the mute pin or the mute control bit requests it, the gain applied to both channels falls from full scale to zero along a raised-cosine curve over 1024 sample periods. When the request is removed, the gain climbs back along the same curve. The second is a hard mute. While the clock recovery loop or the input decoder is out of lock, every output sample is forced to zero at once, unless the bypass control bit is set.

The ramp advances only on samples marked by the per-sample strobe. The curve comes from 33 stored knots, one for each of 32 segments plus the end point, with linear interpolation across the 32 samples of each segment. The block also drives a mute-status flag and a combined status output. The combined output is high only for locked PCM input. After reset the gain sits at zero, so the output starts up muted.

Top module: `soft_mute_ctrl`

## Requirements
- R1: The soft-mute request is mutePin OR muteBit. While the request is high, each strobed sample moves the ramp position one step toward zero gain, stopping at position 1024. While it is low, each strobed sample moves the position one step toward full gain, stopping at position 0. The position never moves without a strobe.
- R2: From full gain with the request held, the 1st strobed sample passes unchanged, the 1024th is still nonzero for a full-scale input, and the 1025th and every later sample are exactly zero.
- R3: The gain at ramp position p (0 < p < 1024) tracks 32767.5·(1+cos(π·p/1024))/65536 within 48/65536. At position 512 the gain is exactly 0x8000/65536.
- R4: Removing the request ramps the gain back up along the same curve. A reversal partway through continues from the current position, with no jump.
- R5: Each output is trunc_toward_zero(sample·g/65536), where sample is a 24-bit two's-complement value and g is the 16-bit unsigned gain. At position 0 the sample passes unchanged. Left and right use the same gain for the same strobe.
- R6: If pllLock AND decLock is 0 and bypassBit is 0 when a sample is strobed, both outputs for that sample are exactly zero, whatever the mute inputs are. The ramp position still follows R1.
- R7: With bypassBit = 1, loss of lock does not mute. The output follows R5.
- R8: lockOut = pllLock AND decLock AND pcmDetect. Non-PCM input or a burst preamble (pcmDetect = 0) drives it low. It follows the inputs combinationally.
- R9: muteFlag is high exactly when the ramp position is 1024 (zero gain) or the hard-mute condition of R6 holds. It is combinational on the current inputs and position.
- R10: During and after reset, the ramp position is 1024, outValid is 0 and both outputs are 0. With muteBit held at 1 the output stays at zero.
- R11: outValid is high for exactly the one cycle after a strobe cycle. leftOut and rightOut change only on that edge and hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe: leftIn/rightIn carry a new sample this cycle |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| mutePin | input | 1 | External soft-mute request |
| muteBit | input | 1 | Control-register soft-mute request |
| bypassBit | input | 1 | 1 disables the hard mute on loss of lock |
| pllLock | input | 1 | Clock recovery locked |
| decLock | input | 1 | Input decoder locked |
| pcmDetect | input | 1 | PCM data present |
| outValid | output | 1 | New output sample registered this cycle |
| leftOut | output | 24 | Scaled left sample |
| rightOut | output | 24 | Scaled right sample |
| muteFlag | output | 1 | Gain at zero or hard mute active |
| lockOut | output | 1 | Combined lock and PCM status |

## Verification
The bench aims at the ends of the ramp. It checks that exactly 1024 attenuated samples come before the first zero. A counter that is off by one would zero the 1024th sample or leak a 1025th. It also checks the curve at its exact midpoint with a negative odd input. There, flooring the product instead of truncating it gives -2 instead of -1. Requests are reversed partway through a ramp. A design that restarted the ramp from one end would show a gain step the curve model rejects. Random lock drops combined with the bypass bit and pending mute requests expose a hard mute that freezes the ramp, ignores the bypass, or only attenuates instead of zeroing.

// File: rtl/mute_pkg.sv
package mute_pkg;
  localparam int GAIN_W    = 16;
  localparam int SEG_COUNT = 32;
  localparam int KNOT_W    = 6;

  typedef struct packed {
    logic              capture;
    logic              hardZero;
    logic              passThru;
    logic [GAIN_W-1:0] gain;
  } dpCtrl_t;

  // Raised-cosine gain at segment boundaries: 32767.5*(1+cos(pi*k/32)).
  function automatic logic [GAIN_W-1:0] cosKnot(input logic [KNOT_W-1:0] k);
    logic [GAIN_W-1:0] v;
    case (k)
      6'd0:  v = 16'd65535;  6'd1:  v = 16'd65377;  6'd2:  v = 16'd64905;
      6'd3:  v = 16'd64124;  6'd4:  v = 16'd63041;  6'd5:  v = 16'd61666;
      6'd6:  v = 16'd60013;  6'd7:  v = 16'd58097;  6'd8:  v = 16'd55938;
      6'd9:  v = 16'd53555;  6'd10: v = 16'd50972;  6'd11: v = 16'd48214;
      6'd12: v = 16'd45307;  6'd13: v = 16'd42279;  6'd14: v = 16'd39160;
      6'd15: v = 16'd35979;  6'd16: v = 16'd32768;  6'd17: v = 16'd29556;
      6'd18: v = 16'd26375;  6'd19: v = 16'd23256;  6'd20: v = 16'd20228;
      6'd21: v = 16'd17321;  6'd22: v = 16'd14563;  6'd23: v = 16'd11980;
      6'd24: v = 16'd9597;   6'd25: v = 16'd7438;   6'd26: v = 16'd5522;
      6'd27: v = 16'd3869;   6'd28: v = 16'd2494;   6'd29: v = 16'd1411;
      6'd30: v = 16'd630;    6'd31: v = 16'd158;
      default: v = 16'd0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/mute_ramp_ctrl.sv
module mute_ramp_ctrl
  import mute_pkg::*;
#(
  parameter int SEG_LEN = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleValid,
  input  logic    mutePin,
  input  logic    muteBit,
  input  logic    bypassBit,
  input  logic    pllLock,
  input  logic    decLock,
  output dpCtrl_t ctl,
  output logic    gainZero,
  output logic    hardNow
);
  localparam int SEG_BITS = $clog2(SEG_LEN);
  localparam int RAMP_LEN = SEG_COUNT * SEG_LEN;
  localparam int POS_W    = $clog2(RAMP_LEN + 1);
  localparam int PROD_W   = GAIN_W + SEG_BITS;

  logic [POS_W-1:0]    pos;
  logic                softReq;
  logic                atTop;
  logic [KNOT_W-1:0]   segIdx;
  logic [SEG_BITS-1:0] segFrac;
  logic [GAIN_W-1:0]   knotA;
  logic [GAIN_W-1:0]   knotB;

  function automatic logic [GAIN_W-1:0] interp(
    input logic [GAIN_W-1:0]   a,
    input logic [GAIN_W-1:0]   b,
    input logic [SEG_BITS-1:0] f
  );
    logic [PROD_W-1:0] drop;
    drop = PROD_W'(a - b) * PROD_W'(f);
    return a - drop[PROD_W-1:SEG_BITS];
  endfunction

  assign softReq  = mutePin | muteBit;
  assign gainZero = (pos == POS_W'(RAMP_LEN));
  assign atTop    = (pos == '0);
  assign hardNow  = !(pllLock && decLock) && !bypassBit;
  assign segIdx   = KNOT_W'(pos >> SEG_BITS);
  assign segFrac  = pos[SEG_BITS-1:0];
  assign knotA    = cosKnot(segIdx);
  assign knotB    = cosKnot(segIdx + KNOT_W'(1));

  always_comb begin
    ctl.capture  = sampleValid;
    ctl.hardZero = hardNow;
    ctl.passThru = atTop;
    ctl.gain     = interp(knotA, knotB, segFrac);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= POS_W'(RAMP_LEN);
    end else if (sampleValid) begin
      if (softReq && !gainZero)   pos <= pos + POS_W'(1);
      else if (!softReq && !atTop) pos <= pos - POS_W'(1);
    end
  end

  // R1: position stays inside the ramp
  a_r1_pos_bound: assert property (@(posedge clk) disable iff (!rstN)
    pos <= POS_W'(RAMP_LEN));
  // R1: one step toward zero gain per requested sample
  a_r1_step_down: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && (mutePin || muteBit) && pos != POS_W'(RAMP_LEN)
    |=> pos == $past(pos) + POS_W'(1));
  // R4: one step back toward full gain per released sample
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !(mutePin || muteBit) && pos != '0
    |=> pos == $past(pos) - POS_W'(1));
  // R1: no strobe, no movement
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(pos));
endmodule

// File: rtl/mute_scale_dp.sv
module mute_scale_dp
  import mute_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  output logic              outValid,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut
);
  localparam int CHANS  = 2;
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  function automatic logic [DATA_W-1:0] scaleSample(
    input logic [DATA_W-1:0] s,
    input logic [GAIN_W-1:0] g
  );
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    prod   = PROD_W'($signed(s)) * $signed(PROD_W'({1'b0, g}));
    biased = prod[PROD_W-1] ? prod + $signed(PROD_W'((1 << GAIN_W) - 1)) : prod;
    return biased[GAIN_W+DATA_W-1:GAIN_W];
  endfunction

  logic [DATA_W-1:0] chIn  [CHANS];
  logic [DATA_W-1:0] chOut [CHANS];

  assign chIn[0]  = leftIn;
  assign chIn[1]  = rightIn;
  assign leftOut  = chOut[0];
  assign rightOut = chOut[1];

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chOut[c] <= '0;
      end else if (ctl.capture) begin
        if (ctl.hardZero)      chOut[c] <= '0;
        else if (ctl.passThru) chOut[c] <= chIn[c];
        else                   chOut[c] <= scaleSample(chIn[c], ctl.gain);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.capture;
  end

  // R6: a hard-muted sample leaves as zero on both channels
  a_r6_hard_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && ctl.hardZero |=> leftOut == '0 && rightOut == '0);
  // R5: full gain passes the sample unchanged
  a_r5_pass_thru: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && ctl.passThru && !ctl.hardZero
    |=> leftOut == $past(leftIn) && rightOut == $past(rightIn));
  // R11: outputs hold between strobes
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(leftOut) && $stable(rightOut) && !outValid);
  // R11: valid follows a strobe by one cycle
  a_r11_valid: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> outValid);
endmodule

// File: rtl/soft_mute_ctrl.sv
module soft_mute_ctrl
  import mute_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SEG_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  input  logic              mutePin,
  input  logic              muteBit,
  input  logic              bypassBit,
  input  logic              pllLock,
  input  logic              decLock,
  input  logic              pcmDetect,
  output logic              outValid,
  output logic [DATA_W-1:0] leftOut,
  output logic [DATA_W-1:0] rightOut,
  output logic              muteFlag,
  output logic              lockOut
);
  dpCtrl_t ctl;
  logic    gainZero;
  logic    hardNow;

  mute_ramp_ctrl #(.SEG_LEN(SEG_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .mutePin(mutePin), .muteBit(muteBit), .bypassBit(bypassBit),
    .pllLock(pllLock), .decLock(decLock),
    .ctl(ctl), .gainZero(gainZero), .hardNow(hardNow)
  );

  mute_scale_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .leftIn(leftIn), .rightIn(rightIn),
    .outValid(outValid), .leftOut(leftOut), .rightOut(rightOut)
  );

  assign muteFlag = gainZero | hardNow;
  assign lockOut  = pllLock & decLock & pcmDetect;

  // R8: combined status never high without PCM data
  a_r8_no_pcm_low: assert property (@(posedge clk) disable iff (!rstN)
    !pcmDetect |-> !lockOut);
endmodule

// File: tb/soft_mute_ctrl_tb_top.sv
module soft_mute_ctrl_tb_top;
  localparam int RAMP = 1024;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN, sampleValid, mutePin, muteBit, bypassBit, pllLock, decLock, pcmDetect;
  logic [23:0] leftIn, rightIn;
  logic outValid, muteFlag, lockOut;
  logic [23:0] leftOut, rightOut;

  int checks = 0;
  int errors = 0;
  int mPos;
  bit done = 0;
  longint lastL, lastR;
  int unsigned seedDummy;

  always #10 clk = ~clk;

  soft_mute_ctrl dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .leftIn(leftIn), .rightIn(rightIn), .mutePin(mutePin), .muteBit(muteBit),
    .bypassBit(bypassBit), .pllLock(pllLock), .decLock(decLock), .pcmDetect(pcmDetect),
    .outValid(outValid), .leftOut(leftOut), .rightOut(rightOut),
    .muteFlag(muteFlag), .lockOut(lockOut)
  );

  function automatic bit hardNow();
    return !(pllLock && decLock) && !bypassBit;
  endfunction

  function automatic real idealOut(longint s, int p, bit hard);
    real g;
    if (hard || p == RAMP) return 0.0;
    if (p == 0) return $itor(s);
    g = 32767.5 * (1.0 + $cos(PI * p / RAMP));
    return $itor(s) * g / 65536.0;
  endfunction

  function automatic real tolFor(longint s, int p, bit hard);
    if (hard || p == 0 || p == RAMP) return 0.0;
    return (s < 0 ? -$itor(s) : $itor(s)) * 48.0 / 65536.0 + 2.0;
  endfunction

  task automatic checkEq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(string tag, longint act, real ideal, real tol);
    real d;
    checks++;
    d = $itor(act) - ideal;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual %0d expected %0f", tag, act, ideal);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic sendCheck(logic [23:0] l, logic [23:0] r, string tag);
    bit hard;
    longint sl, sr;
    hard = hardNow();
    sl = longint'($signed(l));
    sr = longint'($signed(r));
    leftIn = l; rightIn = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    lastL = longint'($signed(leftOut));
    lastR = longint'($signed(rightOut));
    checkEq({tag, " valid R11"}, longint'(outValid), 1);
    checkNear({tag, " left"}, lastL, idealOut(sl, mPos, hard), tolFor(sl, mPos, hard));
    checkNear({tag, " right"}, lastR, idealOut(sr, mPos, hard), tolFor(sr, mPos, hard));
    if (mutePin || muteBit) begin
      if (mPos < RAMP) mPos++;
    end else if (mPos > 0) mPos--;
  endtask

  task automatic sendRand(int n, string tag);
    for (int i = 0; i < n; i++) sendCheck(24'($urandom), 24'($urandom), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    seedDummy = $urandom(32'd4242);
    rstN = 1'b0; sampleValid = 1'b0; leftIn = '0; rightIn = '0;
    mutePin = 1'b0; muteBit = 1'b1; bypassBit = 1'b0;
    pllLock = 1'b1; decLock = 1'b1; pcmDetect = 1'b1;
    mPos = RAMP;
    repeat (3) @(negedge clk);
    // R10: reset state
    checkEq("R10 outValid in reset", longint'(outValid), 0);
    checkEq("R10 leftOut in reset", longint'(leftOut), 0);
    checkEq("R10 muteFlag in reset", longint'(muteFlag), 1);
    rstN = 1'b1;
    @(negedge clk);
    sendRand(20, "R10 start muted");
    checkEq("R10 muteFlag after start", longint'(muteFlag), 1);

    // R4: release ramps up from zero gain
    muteBit = 1'b0;
    sendRand(1100, "R4 ramp up");
    checkEq("R9 muteFlag at full gain", longint'(muteFlag), 0);
    sendRand(20, "R5 pass through");

    // R11: outputs hold with no strobe
    sendCheck(24'h123456, 24'hABCDEF, "R11 base");
    @(negedge clk);
    checkEq("R11 valid drops", longint'(outValid), 0);
    checkEq("R11 left held", longint'($signed(leftOut)), lastL);

    // R1: pin requests; stop at midpoint
    mutePin = 1'b1;
    sendRand(512, "R1 pin ramp");
    sendCheck(24'hFFFFFD, 24'h7FFFFF, "R3 midpoint");
    checkEq("R5 midpoint trunc toward zero", lastL, -1);
    checkEq("R3 midpoint gain 0x8000", lastR, 4194303);

    // R4: reversal partway, then the bit requests again
    mutePin = 1'b0;
    sendRand(200, "R4 reversal");
    muteBit = 1'b1;
    sendRand(300, "R1 bit ramp");
    muteBit = 1'b0;
    sendRand(700, "R4 back up");

    // R2: exact ramp length
    muteBit = 1'b1;
    for (int i = 1; i <= 1025; i++) begin
      sendCheck(24'h7FFFFF, 24'h800001, "R2 length");
      if (i == 1) checkEq("R2 first sample unchanged", lastL, 8388607);
      if (i == 1024) begin
        checks++;
        if (lastL == 0) begin
          errors++;
          $display("FAIL R2 sample 1024 actual 0 expected nonzero");
        end
      end
      if (i == 1025) begin
        checkEq("R2 sample 1025 left", lastL, 0);
        checkEq("R2 sample 1025 right", lastR, 0);
      end
    end
    muteBit = 1'b0;
    sendRand(1030, "R4 recover");

    // R6 / R7 / R9: hard mute and bypass at full gain
    decLock = 1'b0;
    #1 checkEq("R9 muteFlag on unlock", longint'(muteFlag), 1);
    sendCheck(24'h3FFFFF, 24'hC00000, "R6 decoder unlock");
    checkEq("R6 left zero", lastL, 0);
    pllLock = 1'b0; decLock = 1'b1;
    sendCheck(24'h000777, 24'hFFF000, "R6 pll unlock");
    checkEq("R6 right zero", lastR, 0);
    bypassBit = 1'b1;
    #1 checkEq("R9 muteFlag with bypass", longint'(muteFlag), 0);
    sendCheck(24'h2468AC, 24'hFEDCBA, "R7 bypass");
    checkEq("R7 bypass passes", lastL, 24'h2468AC);
    bypassBit = 1'b0; pllLock = 1'b1;

    // R8: combined status, all combinations
    for (int k = 0; k < 8; k++) begin
      pllLock = k[0]; decLock = k[1]; pcmDetect = k[2];
      #1 checkEq("R8 lockOut", longint'(lockOut), longint'(k == 7));
      checkEq("R9 muteFlag vs lock", longint'(muteFlag), longint'(!(k[0] && k[1])));
      @(negedge clk);
    end

    // Random mix: requests, lock drops, bypass (R6 ramp keeps moving)
    pllLock = 1'b1; decLock = 1'b1; pcmDetect = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 200 == 0) mutePin = ~mutePin;
      if ($urandom % 200 == 0) muteBit = ~muteBit;
      decLock   = ($urandom % 8) != 0;
      pllLock   = ($urandom % 16) != 0;
      bypassBit = ($urandom % 4) == 0;
      pcmDetect = ($urandom % 2) == 0;
      #1 checkEq("R9 muteFlag random", longint'(muteFlag),
                 longint'((mPos == RAMP) || hardNow()));
      checkEq("R8 lockOut random", longint'(lockOut),
              longint'(pllLock && decLock && pcmDetect));
      sendCheck(24'($urandom), 24'($urandom), "R6 random mix");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule